// File: doc/BRIEF.md
# Synthesizer Serial Programming Port

This block is the control front end of a frequency synthesizer. A host writes 21-bit words over a three-wire serial link made of a serial clock, a data line and a latch strobe. Bits enter most significant first while the latch strobe is low. When the strobe rises, the two lowest bits of the word pick one of three targets: the reference divider, the dual-modulus A/B divider or the operating mode register. The selected target takes its fields from the word. A one-cycle strobe then tells the divider logic downstream to reload.

The block also works out the power state. Two external enable pins and a power-enable bit held in the mode register give the receive, transmit, power-down, inactive or disabled state, together with the synthesizer enable. The stored contents survive every power state, and the serial port accepts writes in all of them.

All five inputs are brought into a fast system clock through two-flop synchronizers, and edges are detected there. A word whose bit count is not exactly 21 when the strobe rises is thrown away and flagged.

Top module: `syn_ctl_port`

## Requirements
- R1: On each rising edge of `ser_clk` while `ser_le` is low, one bit of `ser_data` is shifted in. The first bit becomes frame bit 20 and the last bit becomes frame bit 0.
- R2: Rising edges of `ser_clk` seen while `ser_le` is high shift nothing. This includes an edge that arrives together with the rise of `ser_le`.
- R3: When `ser_le` rises after exactly 21 bits, frame bits [1:0] select the target. 2'b00 writes the reference divider, 2'b01 (bit 0 set) writes the A/B divider and 2'b10 writes the mode register. 2'b11 writes nothing and produces no strobe.
- R4: A reference write loads `ref_div` from frame bits [16:2], with bit 2 as the LSB. Frame bits 17 to 20 are ignored.
- R5: An A/B write loads `a_div` from frame bits [8:2] and `b_div` from frame bits [19:9]. Frame bit 20 is ignored.
- R6: A mode write sets `mode_bits[k]` to frame bit k+2 for k = 0, 2..8 and 13..15. Mode bits 1 and 9..12 always read as zero, and frame bits 18 to 20 are ignored.
- R7: When `ser_le` rises after a bit count other than 21, `frame_err` pulses for exactly one cycle and no register changes.
- R8: Every accepted write raises exactly one of `upd_ref`, `upd_ab` or `upd_mode` for one cycle, in the same cycle that the new value appears.
- R9: `synth_en` equals `mode_bits[0]` AND (`pe1_pin` OR `pe2_pin`).
- R10: `pwr_state` encodes the state as follows. 0 is disabled, used when `mode_bits[0]` is clear whatever the pins are. With the bit set, 1 is power-down (pins 00), 2 is receive (pe1=1, pe2=1), 3 is transmit (pe1=1, pe2=0) and 4 is inactive (pe1=0, pe2=1).
- R11: Register contents do not change across power-state changes, and serial writes are accepted in every state, including the disabled one.
- R12: While `rst` is high on a rising edge of `clk`, all registers clear to zero, `pwr_state` becomes 0 and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than ser_clk |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Latch strobe; low to shift, rising edge to commit |
| pe1_pin | input | 1 | External power enable 1 |
| pe2_pin | input | 1 | External power enable 2 |
| ref_div | output | 15 | Stored reference divider |
| a_div | output | 7 | Stored A (swallow) count |
| b_div | output | 11 | Stored B (main) count |
| mode_bits | output | 16 | Stored mode bits; bit 0 is the power-enable bit |
| upd_ref | output | 1 | One-cycle reload strobe for the reference divider |
| upd_ab | output | 1 | One-cycle reload strobe for the A/B divider |
| upd_mode | output | 1 | One-cycle strobe for a mode register write |
| frame_err | output | 1 | One-cycle flag for a discarded frame |
| synth_en | output | 1 | Synthesizer enable |
| pwr_state | output | 3 | Decoded power state |

## Verification
Two things can meet in one cycle. The latch strobe can rise together with a serial clock edge, and a mode write that changes the power-enable bit can land together with a change of the enable pins. The bench provokes the first by driving a 22nd clock edge at the same instant as the rising strobe. It judges the result by requiring that the register holds the 21 bits sent before that edge. It provokes the second by switching both pins at the instant the strobe rises, and requires the state that follows to match the new pins decoded with the new bit.

// File: rtl/syn_ctl_pkg.sv
package syn_ctl_pkg;
    parameter int FRAME_W = 21;
    parameter int ADDR_W  = 2;
    parameter int R_W     = 15;
    parameter int A_W     = 7;
    parameter int B_W     = 11;
    parameter int M_W     = 16;
    parameter logic [M_W-1:0] MODE_MASK = 16'hE1FD;
    localparam int CNT_W  = $clog2(FRAME_W + 2);

    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic [ADDR_W-1:0] {
        TGT_REF  = 2'b00,
        TGT_AB   = 2'b01,
        TGT_MODE = 2'b10,
        TGT_NONE = 2'b11
    } tgt_e;

    typedef enum logic [2:0] {
        PWR_OFF  = 3'd0,
        PWR_DOWN = 3'd1,
        PWR_RX   = 3'd2,
        PWR_TX   = 3'd3,
        PWR_IDLE = 3'd4
    } pwr_e;

    typedef struct packed {
        logic [R_W-1:0] rdiv;
        logic [A_W-1:0] adiv;
        logic [B_W-1:0] bdiv;
        logic [M_W-1:0] mode;
    } regs_t;

    function automatic logic [R_W-1:0] fld_ref(frame_t f);
        return f[ADDR_W +: R_W];
    endfunction

    function automatic logic [A_W-1:0] fld_a(frame_t f);
        return f[ADDR_W +: A_W];
    endfunction

    function automatic logic [B_W-1:0] fld_b(frame_t f);
        return f[ADDR_W + A_W +: B_W];
    endfunction

    function automatic logic [M_W-1:0] fld_mode(frame_t f);
        return f[ADDR_W +: M_W] & MODE_MASK;
    endfunction

    function automatic pwr_e pwr_decode(logic pe_bit, logic p1, logic p2);
        if (!pe_bit) return PWR_OFF;
        case ({p1, p2})
            2'b11:   return PWR_RX;
            2'b10:   return PWR_TX;
            2'b01:   return PWR_IDLE;
            default: return PWR_DOWN;
        endcase
    endfunction
endpackage

// File: rtl/syn_ctl_sync.sv
module syn_ctl_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta, stab;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta <= RST_VAL[i];
                stab <= RST_VAL[i];
            end else begin
                meta <= d[i];
                stab <= meta;
            end
        end
        assign q[i] = stab;
    end
endmodule

// File: rtl/syn_ctl_shift.sv
module syn_ctl_shift
    import syn_ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_s,
    input  logic   sdata_s,
    input  logic   le_s,
    output frame_t word,
    output logic   word_vld,
    output logic   len_err
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_W);

    logic             sclk_d, le_d;
    frame_t           sr;
    logic [CNT_W-1:0] cnt;
    logic             sclk_rise, le_rise;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign le_rise   = le_s & ~le_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b0;
            le_d     <= 1'b1;
            sr       <= '0;
            cnt      <= '0;
            word     <= '0;
            word_vld <= 1'b0;
            len_err  <= 1'b0;
        end else begin
            sclk_d   <= sclk_s;
            le_d     <= le_s;
            word_vld <= 1'b0;
            len_err  <= 1'b0;
            if (le_rise) begin
                cnt <= '0;
                if (cnt == CNT_GOOD) begin
                    word     <= sr;
                    word_vld <= 1'b1;
                end else begin
                    len_err  <= 1'b1;
                end
            end else if (sclk_rise && !le_s) begin
                sr <= {sr[FRAME_W-2:0], sdata_s};
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end
        end
    end

    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        len_err |=> !len_err);

    // R2
    no_shift_high_chk: assert property (@(posedge clk) disable iff (rst)
        le_s |=> $stable(sr));

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && !le_s && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/syn_ctl_regs.sv
module syn_ctl_regs
    import syn_ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  frame_t word,
    input  logic   word_vld,
    output regs_t  regs,
    output logic   upd_ref,
    output logic   upd_ab,
    output logic   upd_mode
);
    tgt_e tgt;
    assign tgt = tgt_e'(word[ADDR_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs     <= '0;
            upd_ref  <= 1'b0;
            upd_ab   <= 1'b0;
            upd_mode <= 1'b0;
        end else begin
            upd_ref  <= 1'b0;
            upd_ab   <= 1'b0;
            upd_mode <= 1'b0;
            if (word_vld) begin
                case (tgt)
                    TGT_REF: begin
                        regs.rdiv <= fld_ref(word);
                        upd_ref   <= 1'b1;
                    end
                    TGT_AB: begin
                        regs.adiv <= fld_a(word);
                        regs.bdiv <= fld_b(word);
                        upd_ab    <= 1'b1;
                    end
                    TGT_MODE: begin
                        regs.mode <= fld_mode(word);
                        upd_mode  <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({upd_ref, upd_ab, upd_mode}));

    // R11
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_ref |-> $stable(regs.rdiv));

    // R11
    ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_ab |-> ($stable(regs.adiv) && $stable(regs.bdiv)));

    // R6
    mode_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (regs.mode & ~MODE_MASK) == '0);
endmodule

// File: rtl/syn_ctl_port.sv
module syn_ctl_port
    import syn_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ser_clk,
    input  logic            ser_data,
    input  logic            ser_le,
    input  logic            pe1_pin,
    input  logic            pe2_pin,
    output logic [R_W-1:0]  ref_div,
    output logic [A_W-1:0]  a_div,
    output logic [B_W-1:0]  b_div,
    output logic [M_W-1:0]  mode_bits,
    output logic            upd_ref,
    output logic            upd_ab,
    output logic            upd_mode,
    output logic            frame_err,
    output logic            synth_en,
    output logic [2:0]      pwr_state
);
    localparam int N_IN = 5;

    logic [N_IN-1:0] raw_in, syn_in;
    frame_t          word;
    logic            word_vld;
    regs_t           regs;
    pwr_e            st;

    assign raw_in = {pe2_pin, pe1_pin, ser_le, ser_data, ser_clk};

    syn_ctl_sync #(.W(N_IN), .RST_VAL(5'b00100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    syn_ctl_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (syn_in[0]),
        .sdata_s  (syn_in[1]),
        .le_s     (syn_in[2]),
        .word     (word),
        .word_vld (word_vld),
        .len_err  (frame_err)
    );

    syn_ctl_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .word     (word),
        .word_vld (word_vld),
        .regs     (regs),
        .upd_ref  (upd_ref),
        .upd_ab   (upd_ab),
        .upd_mode (upd_mode)
    );

    assign ref_div   = regs.rdiv;
    assign a_div     = regs.adiv;
    assign b_div     = regs.bdiv;
    assign mode_bits = regs.mode;

    assign st        = pwr_decode(regs.mode[0], syn_in[3], syn_in[4]);
    assign pwr_state = st;
    assign synth_en  = regs.mode[0] & (syn_in[3] | syn_in[4]);

    // R9
    en_needs_bit_chk: assert property (@(posedge clk) disable iff (rst)
        synth_en |-> mode_bits[0]);

    // R10
    active_state_en_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PWR_RX || pwr_state == PWR_TX || pwr_state == PWR_IDLE) |-> synth_en);

    // R10
    off_state_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PWR_OFF || pwr_state == PWR_DOWN) |-> !synth_en);

    // R7
    err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !(upd_ref || upd_ab || upd_mode));
endmodule

// File: tb/tb_syn_ctl_port.sv
module tb_syn_ctl_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b1;
    logic        pe1_pin = 1'b0, pe2_pin = 1'b0;
    logic [14:0] ref_div;
    logic [6:0]  a_div;
    logic [10:0] b_div;
    logic [15:0] mode_bits;
    logic        upd_ref, upd_ab, upd_mode, frame_err, synth_en;
    logic [2:0]  pwr_state;

    always #(CLK_PERIOD/2) clk = ~clk;

    syn_ctl_port dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .pe1_pin(pe1_pin), .pe2_pin(pe2_pin), .ref_div(ref_div), .a_div(a_div),
        .b_div(b_div), .mode_bits(mode_bits), .upd_ref(upd_ref), .upd_ab(upd_ab),
        .upd_mode(upd_mode), .frame_err(frame_err), .synth_en(synth_en),
        .pwr_state(pwr_state)
    );

    typedef struct {
        int          kind;
        logic [14:0] r;
        logic [6:0]  a;
        logic [10:0] b;
        logic [15:0] m;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    logic [14:0] m_r = '0;
    logic [6:0]  m_a = '0;
    logic [10:0] m_b = '0;
    logic [15:0] m_m = '0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_state(logic pe, logic p1, logic p2);
        if (!pe) return 3'd0;
        if (p1 && p2) return 3'd2;
        if (p1) return 3'd3;
        if (p2) return 3'd4;
        return 3'd1;
    endfunction

    // Monitor: every strobe or error pops one expected item
    always @(negedge clk) begin
        if (!rst && (upd_ref || upd_ab || upd_mode || frame_err)) begin
            int k;
            k = frame_err ? 3 : upd_ref ? 0 : upd_ab ? 1 : 2;
            if (sb.size() == 0) begin
                chk(0, "R3/R8 unexpected strobe", k, 99);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(k == e.kind && $countones({upd_ref, upd_ab, upd_mode, frame_err}) == 1,
                    {e.req, " R8 strobe kind"}, k, e.kind);
                chk(ref_div == e.r, {e.req, " R4 ref_div"}, ref_div, e.r);
                chk(a_div == e.a, {e.req, " R5 a_div"}, a_div, e.a);
                chk(b_div == e.b, {e.req, " R5 b_div"}, b_div, e.b);
                chk(mode_bits == e.m, {e.req, " R6 mode_bits"}, mode_bits, e.m);
            end
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Driver: coinc 1 = extra ser_clk edge with LE rise; 2 = pins change with LE rise
    task automatic send(input logic [31:0] bits, input int n, input string req,
                        input int coinc = 0, input logic np1 = 0, input logic np2 = 0);
        logic [20:0] w;
        exp_t e;
        w = bits[20:0];
        if (n == 21) begin
            case (w[1:0])
                2'b00: begin m_r = w[16:2]; e.kind = 0; end
                2'b01: begin m_a = w[8:2]; m_b = w[19:9]; e.kind = 1; end
                2'b10: begin m_m = w[17:2] & 16'hE1FD; e.kind = 2; end
                default: e.kind = -1;
            endcase
        end else begin
            e.kind = 3;
        end
        e.r = m_r; e.a = m_a; e.b = m_b; e.m = m_m; e.req = req;
        if (e.kind >= 0) sb.push_back(e);
        ser_le = 1'b0;
        wclk(HALF);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            wclk(HALF);
            ser_clk = 1'b1;
            wclk(HALF);
            ser_clk = 1'b0;
        end
        wclk(HALF);
        if (coinc == 1) begin
            ser_data = ~ser_data;
            ser_clk  = 1'b1;
        end
        if (coinc == 2) begin
            pe1_pin = np1;
            pe2_pin = np2;
        end
        ser_le = 1'b1;
        wclk(HALF);
        ser_clk = 1'b0;
        wclk(12);
    endtask

    task automatic set_pins(input logic p1, input logic p2);
        pe1_pin = p1;
        pe2_pin = p2;
        wclk(6);
        @(negedge clk);
    endtask

    task automatic chk_pwr(input string req);
        logic [2:0] es;
        logic       ee;
        es = exp_state(m_m[0], pe1_pin, pe2_pin);
        ee = m_m[0] & (pe1_pin | pe2_pin);
        chk(pwr_state == es, {req, " R10 pwr_state"}, pwr_state, es);
        chk(synth_en == ee, {req, " R9 synth_en"}, synth_en, ee);
    endtask

    task automatic chk_regs(input string req);
        @(negedge clk);
        chk(ref_div == m_r, {req, " ref_div"}, ref_div, m_r);
        chk(a_div == m_a && b_div == m_b, {req, " a/b"}, {a_div, b_div}, {m_a, m_b});
        chk(mode_bits == m_m, {req, " mode"}, mode_bits, m_m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wclk(5);
        @(negedge clk);
        // R12: values held during reset
        chk(ref_div == 0 && a_div == 0 && b_div == 0 && mode_bits == 0, "R12 regs zero",
            {ref_div, a_div, b_div, mode_bits}, 0);
        chk(pwr_state == 0 && !synth_en, "R12 state off", pwr_state, 0);
        chk(!upd_ref && !upd_ab && !upd_mode && !frame_err, "R12 strobes low",
            {upd_ref, upd_ab, upd_mode, frame_err}, 0);
        rst = 1'b0;
        wclk(8);
        chk_regs("R12 after reset");

        // R1 R3 R4: reference write, top bits set and ignored
        send(32'h1E_96_94 | (32'h5A5A << 2) | 32'h1E0000, 21, "R1 R3 R4 ref");
        send({11'd0, 2'b11, 17'h0}, 21, "R4 ref zero");
        send(32'h0 | (32'h1234 << 2), 21, "R4 ref pattern");
        // R5: A/B write, bit 20 set
        send(32'h100000 | (32'h5A3 << 9) | (32'h55 << 2) | 32'h1, 21, "R5 ab");
        send((32'h7FF << 9) | (32'h7F << 2) | 32'h1, 21, "R5 ab ones");
        // R6: mode write with all ones, bit0 set
        send(32'h1FFFFE, 21, "R6 mode ones");
        chk_regs("R6 mode held");

        // R9 R10: each pin pattern with bit set
        set_pins(1, 1); chk_pwr("R10 rx");
        set_pins(1, 0); chk_pwr("R10 tx");
        set_pins(0, 0); chk_pwr("R10 down");
        set_pins(0, 1); chk_pwr("R10 idle");
        // R11: retention across states
        chk_regs("R11 retain through states");

        // R7: short and long frames discarded
        send(32'h0ABCD0, 20, "R7 short");
        send(32'h3ABCD1, 22, "R7 long");
        chk_regs("R7 unchanged");

        // R3: address 11 writes nothing
        send(32'h1FFFFF, 21, "R3 addr11");
        chk_regs("R3 addr11 no change");

        // R2: extra ser_clk edge with the LE rise is not shifted
        send((32'h2AAA << 2), 21, "R2 coincident edge", 1);
        chk_regs("R2 coincident edge");

        // R9 R10 R11: clear the enable bit, pins high, state disabled
        send(32'h1FFFF8 & 32'h0FFFFA | 32'h2, 21, "R6 mode bit clear");
        set_pins(1, 1); chk_pwr("R10 disabled pins 11");
        set_pins(1, 0); chk_pwr("R9 disabled pins 10");
        // R11: write accepted while disabled
        send((32'h0777 << 2), 21, "R11 write while off");
        chk_regs("R11 write while off");

        // Coincidence: mode write sets bit while pins change at LE rise
        send(32'h000006, 21, "R10 coincident pins", 2, 1'b0, 1'b1);
        wclk(4); @(negedge clk);
        chk_pwr("R10 coincident pins");
        send(32'h000002, 21, "R9 coincident clear", 2, 1'b1, 1'b1);
        wclk(4); @(negedge clk);
        chk_pwr("R9 coincident clear");

        wclk(20);
        chk(sb.size() == 0, "R8 all expected strobes seen", sb.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule